// File: doc/BRIEF.md
# Halfword burst writer with lane masking

This block sits between a host that issues 32-bit word accesses and a sequencer that moves data to a 16-bit DDR2 device in fixed bursts of four beats. A host request carries a logical word address, a direction, and a flag that selects either one word or a pair of consecutive words. The block turns that request into one or two burst commands at halfword-granular physical addresses. It supplies write data and a per-lane write mask for each beat the sequencer takes. For reads, it gathers the beats the sequencer delivers.

Bursts always start on a four-halfword boundary and always run for four beats. Words that do not fill a burst are handled with the mask on writes. On reads, the unused beats are simply dropped. A two-word write that starts on an odd word straddles two bursts. A one-word write or any read always fits in one burst.

Top module: `ddr_burst_wmask`

## Requirements
- R1: After reset, req_ready is 1, and dram_cmd_valid, rsp_valid, wr_dm and wr_dq are all 0.
- R2: A request at logical word address L issues its first burst at physical halfword address 4*floor(L/2). Bits 1:0 of dram_cmd_addr are always 0. A logical address maps to physical halfword address 2*L, so L=0x200000 lands at 0x400000. Any second burst sits at the first burst's address plus 4, modulo 2^(LAW+1).
- R3: Within a burst, beat k carries physical halfword base+k. A word occupies beats 2*(L mod 2) and 2*(L mod 2)+1, with its low halfword on the earlier beat. Write word 0 is req_wdata[31:0] and word 1 is req_wdata[63:32].
- R4: A one-word write (req_pair=0) uses one burst. Its two word beats carry wr_dm=2'b00. The other two beats carry wr_dm=2'b11 and wr_dq=0. Both mask bits are always equal.
- R5: A two-word write at an even L uses one burst. All four beats are unmasked and carry word 0 low, word 0 high, word 1 low, word 1 high, in that order.
- R6: A two-word write at an odd L uses two bursts. The first burst masks beats 0 and 1 and writes word 0 on beats 2 and 3. The second burst, at base+4, writes word 1 on beats 0 and 1 and masks beats 2 and 3.
- R7: A read uses exactly one burst, whatever the value of req_pair. One cycle after the burst's dram_done, rsp_valid pulses for one cycle. rsp_rdata is then {beat[2s+1], beat[2s]}, where s = L mod 2.
- R8: During read bursts and while idle, wr_dm and wr_dq are 0.
- R9: req_ready is 0 from the accepting edge until the edge that ends the last burst. A request held on the inputs meanwhile is not accepted and does not alter dram_cmd_addr.
- R10: A burst is never shortened. dram_cmd_valid and dram_cmd_addr hold until dram_done, however many cycles the sequencer waits after the fourth beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_pair | input | 1 | 1 = two consecutive words (writes only) |
| req_addr | input | LAW (24) | Logical word address |
| req_wdata | input | 4*DQW (64) | Word 0 in the low half, word 1 in the high half |
| rsp_valid | output | 1 | Read word valid, one-cycle pulse |
| rsp_rdata | output | 2*DQW (32) | Read word |
| dram_cmd_valid | output | 1 | Burst in progress |
| dram_cmd_write | output | 1 | Current burst is a write |
| dram_cmd_addr | output | LAW+1 (25) | Physical halfword address of the burst |
| dram_beat | input | 1 | Sequencer takes or delivers one beat |
| dram_done | input | 1 | Pulse ending the current burst |
| wr_dq | output | DQW (16) | Write data for the current beat |
| wr_dm | output | DQW/8 (2) | Write mask for the current beat, 1 = keep memory |
| rd_dq | input | DQW (16) | Read data, sampled when dram_beat is high |

## Verification
The hardest case to reach is the two-burst write. It needs a paired write at an odd address, and its second burst has to wrap correctly at the top of the address space. The stimulus sweeps every access kind over a set of addresses that mixes even and odd values. That set includes the two highest word addresses and the low boundary. For each beat of both bursts, the bench checks both the mask and the data. Separate runs hold a competing request on the inputs for a whole burst, and let the sequencer idle after the last beat before it ends the burst.

// File: rtl/ddr_bw_pkg.sv
package ddr_bw_pkg;

  localparam int BURST_LEN = 4;
  localparam int BEAT_IW   = $clog2(BURST_LEN);

  typedef logic [BEAT_IW-1:0] beat_t;

  // Word slot of a beat counted across both bursts of a request (0..3).
  function automatic logic [1:0] word_slot(input logic second, input beat_t beat);
    return {second, beat[BEAT_IW-1]};
  endfunction

  // True when the beat carries host data rather than a masked filler.
  function automatic logic beat_live(input logic odd, input logic pair,
                                     input logic second, input beat_t beat);
    logic [1:0] slot;
    logic [1:0] first;
    slot  = word_slot(second, beat);
    first = {1'b0, odd};
    return (slot == first) || (pair && (slot == first + 2'd1));
  endfunction

  // Which host word (0 or 1) a live beat belongs to.
  function automatic logic word_pick(input logic odd, input logic second, input beat_t beat);
    logic [1:0] d;
    d = word_slot(second, beat) - {1'b0, odd};
    return d[0];
  endfunction

endpackage

// File: rtl/ddr_bw_addrmap.sv
module ddr_bw_addrmap #(
  parameter int LAW = 24,
  parameter int PAW = LAW + 1
) (
  input  logic [LAW-1:0] laddr,
  input  logic           second,
  output logic [PAW-1:0] paddr,
  output logic           odd
);

  // Word address to halfword address: one halfword per byte lane pair.
  function automatic logic [PAW-1:0] to_halfword(input logic [LAW-1:0] w);
    return {w, 1'b0};
  endfunction

  logic [LAW-2:0] pair_idx;

  assign pair_idx = laddr[LAW-1:1] + {{(LAW-2){1'b0}}, second};
  assign paddr    = to_halfword({pair_idx, 1'b0});
  assign odd      = laddr[0];

endmodule

// File: rtl/ddr_bw_ctrl.sv
module ddr_bw_ctrl
  import ddr_bw_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  req_valid,
  output logic  req_ready,
  output logic  accept,
  input  logic  need_two,
  input  logic  is_read,
  input  logic  dram_beat,
  input  logic  dram_done,
  output logic  busy,
  output logic  second,
  output beat_t beat_idx,
  output logic  beat_take,
  output logic  read_end
);

  logic  busy_q, second_q;
  beat_t cnt_q;

  assign req_ready = !busy_q;
  assign accept    = req_valid && !busy_q;
  assign busy      = busy_q;
  assign second    = second_q;
  assign beat_idx  = cnt_q;
  assign beat_take = busy_q && dram_beat && !dram_done;
  assign read_end  = busy_q && dram_done && is_read;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      second_q <= 1'b0;
      cnt_q    <= '0;
    end else if (accept) begin
      busy_q   <= 1'b1;
      second_q <= 1'b0;
      cnt_q    <= '0;
    end else if (busy_q) begin
      if (dram_done) begin
        cnt_q <= '0;
        if (need_two && !second_q) begin
          second_q <= 1'b1;
        end else begin
          busy_q   <= 1'b0;
          second_q <= 1'b0;
        end
      end else if (dram_beat) begin
        cnt_q <= cnt_q + beat_t'(1);
      end
    end
  end

  // R10: only the sequencer's done pulse can end a burst
  p_burst_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !dram_done |=> busy);

  // R6: a second burst exists only for requests that need two
  p_second_needs_two_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy && second |-> need_two);

endmodule

// File: rtl/ddr_bw_wbeat.sv
module ddr_bw_wbeat
  import ddr_bw_pkg::*;
#(
  parameter int DQW = 16,
  parameter int DMW = DQW / 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               active,
  input  logic               odd,
  input  logic               pair,
  input  logic               second,
  input  beat_t              beat,
  input  logic [4*DQW-1:0]   wdata,
  output logic [DQW-1:0]     wr_dq,
  output logic [DMW-1:0]     wr_dm
);

  logic           live;
  logic           hi_word;
  logic [DQW-1:0] halves [4];

  generate
    for (genvar h = 0; h < 4; h++) begin : g_half
      assign halves[h] = wdata[h*DQW +: DQW];
    end
  endgenerate

  assign live    = active && beat_live(odd, pair, second, beat);
  assign hi_word = word_pick(odd, second, beat);
  assign wr_dq   = live ? halves[{hi_word, beat[0]}] : '0;

  generate
    for (genvar l = 0; l < DMW; l++) begin : g_lane
      assign wr_dm[l] = active && !live;
    end
  endgenerate

  // R4: a masked beat never drives data
  p_masked_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dm != '0) |-> (wr_dq == '0));

endmodule

// File: rtl/ddr_bw_rgather.sv
module ddr_bw_rgather
  import ddr_bw_pkg::*;
#(
  parameter int DQW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  beat_t            beat,
  input  logic [DQW-1:0]   rd_dq,
  input  logic             fire,
  input  logic             odd,
  output logic             rsp_valid,
  output logic [2*DQW-1:0] rsp_rdata
);

  logic [BURST_LEN*DQW-1:0] cap_q;

  // Pick the word's two beats; the earlier beat sits in the lower bits.
  function automatic logic [2*DQW-1:0] pick_word(input logic [BURST_LEN*DQW-1:0] c,
                                                 input logic o);
    return c[o*2*DQW +: 2*DQW];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= '0;
    end else begin
      for (int i = 0; i < BURST_LEN; i++) begin
        if (take && beat == beat_t'(i)) cap_q[i*DQW +: DQW] <= rd_dq;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= fire;
      if (fire) rsp_rdata <= pick_word(cap_q, odd);
    end
  end

endmodule

// File: rtl/ddr_burst_wmask.sv
module ddr_burst_wmask
  import ddr_bw_pkg::*;
#(
  parameter int LAW = 24,
  parameter int DQW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic                 req_pair,
  input  logic [LAW-1:0]       req_addr,
  input  logic [4*DQW-1:0]     req_wdata,
  output logic                 rsp_valid,
  output logic [2*DQW-1:0]     rsp_rdata,
  output logic                 dram_cmd_valid,
  output logic                 dram_cmd_write,
  output logic [LAW:0]         dram_cmd_addr,
  input  logic                 dram_beat,
  input  logic                 dram_done,
  output logic [DQW-1:0]       wr_dq,
  output logic [DQW/8-1:0]     wr_dm,
  input  logic [DQW-1:0]       rd_dq
);

  localparam int PAW = LAW + 1;
  localparam int DMW = DQW / 8;

  logic [LAW-1:0]   lat_addr;
  logic             lat_write, lat_pair;
  logic [4*DQW-1:0] lat_wdata;

  logic  accept, busy, second, odd, need_two, beat_take, read_end;
  beat_t beat_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_addr  <= '0;
      lat_write <= 1'b0;
      lat_pair  <= 1'b0;
      lat_wdata <= '0;
    end else if (accept) begin
      lat_addr  <= req_addr;
      lat_write <= req_write;
      lat_pair  <= req_pair;
      lat_wdata <= req_wdata;
    end
  end

  assign need_two       = lat_write && lat_pair && odd;
  assign dram_cmd_valid = busy;
  assign dram_cmd_write = busy && lat_write;

  ddr_bw_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .accept    (accept),
    .need_two  (need_two),
    .is_read   (!lat_write),
    .dram_beat (dram_beat),
    .dram_done (dram_done),
    .busy      (busy),
    .second    (second),
    .beat_idx  (beat_idx),
    .beat_take (beat_take),
    .read_end  (read_end)
  );

  ddr_bw_addrmap #(.LAW(LAW), .PAW(PAW)) u_map (
    .laddr  (lat_addr),
    .second (second),
    .paddr  (dram_cmd_addr),
    .odd    (odd)
  );

  ddr_bw_wbeat #(.DQW(DQW), .DMW(DMW)) u_wbeat (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (busy && lat_write),
    .odd    (odd),
    .pair   (lat_pair),
    .second (second),
    .beat   (beat_idx),
    .wdata  (lat_wdata),
    .wr_dq  (wr_dq),
    .wr_dm  (wr_dm)
  );

  ddr_bw_rgather #(.DQW(DQW)) u_rg (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (beat_take && !lat_write),
    .beat      (beat_idx),
    .rd_dq     (rd_dq),
    .fire      (read_end),
    .odd       (odd),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  // R10: command address is steady for the whole burst
  p_addr_steady_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dram_cmd_valid && !dram_done |=> $stable(dram_cmd_addr));

  // R8: no mask activity on read bursts
  p_read_unmasked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dram_cmd_valid && !dram_cmd_write |-> wr_dm == '0);

  // R7: a response follows the done of a read burst
  p_rsp_after_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(dram_done && dram_cmd_valid && !dram_cmd_write));

  // R6: the follow-on burst lands one aligned group higher
  p_second_base_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(second) |-> dram_cmd_addr == $past(dram_cmd_addr) + PAW'(4));

  // R9: a burst starts only from an accepted handshake
  p_start_on_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dram_cmd_valid) |-> $past(req_valid && req_ready));

endmodule

// File: tb/sim_ddr_burst_wmask.sv
`timescale 1ns/1ps
module sim_ddr_burst_wmask;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_pair = 1'b0;
  logic [23:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic        dram_beat = 1'b0, dram_done = 1'b0;
  logic [15:0] rd_dq = '0;
  logic        req_ready, rsp_valid, dram_cmd_valid, dram_cmd_write;
  logic [31:0] rsp_rdata;
  logic [24:0] dram_cmd_addr;
  logic [15:0] wr_dq;
  logic [1:0]  wr_dm;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  ddr_burst_wmask u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_pair(req_pair), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .dram_cmd_valid(dram_cmd_valid), .dram_cmd_write(dram_cmd_write),
    .dram_cmd_addr(dram_cmd_addr), .dram_beat(dram_beat), .dram_done(dram_done),
    .wr_dq(wr_dq), .wr_dm(wr_dm), .rd_dq(rd_dq)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [24:0] exp_base(input logic [23:0] a, input int b);
    logic [31:0] t;
    t = ({8'h0, a} >> 1) + b;
    return 25'(t << 2);
  endfunction

  // Returns {live, data} for halfword h = 4*b+k counted from the first burst base.
  function automatic logic [16:0] exp_beat(input logic [23:0] a, input bit pair,
                                           input logic [63:0] wd, input int b, input int k);
    int h, first, n;
    h = 4*b + k;
    first = 2 * int'(a[0]);
    n = pair ? 4 : 2;
    if (h >= first && h < first + n) return {1'b1, wd[16*(h-first) +: 16]};
    return 17'h0;
  endfunction

  task automatic do_write(input logic [23:0] a, input bit pair, input logic [63:0] wd,
                          input int stall, input bit hold);
    int nb;
    string tag;
    logic [16:0] e;
    nb  = (pair && a[0]) ? 2 : 1;
    tag = pair ? (a[0] ? "R6" : "R5") : "R4";
    @(negedge clk);
    chk(req_ready == 1'b1, "R9", 64'(req_ready), 64'h1);
    req_valid = 1'b1; req_write = 1'b1; req_pair = pair; req_addr = a; req_wdata = wd;
    @(negedge clk);
    if (hold) begin
      req_addr = ~a; req_pair = ~pair; req_wdata = ~wd;
    end else begin
      req_valid = 1'b0;
    end
    for (int b = 0; b < nb; b++) begin
      chk(dram_cmd_valid && dram_cmd_write, tag, {dram_cmd_valid, dram_cmd_write}, 2'b11);
      chk(dram_cmd_addr == exp_base(a, b), "R2", 64'(dram_cmd_addr), 64'(exp_base(a, b)));
      for (int k = 0; k < 4; k++) begin
        e = exp_beat(a, pair, wd, b, k);
        chk(wr_dq == e[15:0], "R3", 64'(wr_dq), 64'(e[15:0]));
        chk(wr_dm == (e[16] ? 2'b00 : 2'b11), tag, 64'(wr_dm), e[16] ? 64'h0 : 64'h3);
        if (hold) chk(req_ready == 1'b0, "R9", 64'(req_ready), 64'h0);
        dram_beat = 1'b1;
        @(negedge clk);
        dram_beat = 1'b0;
      end
      for (int s = 0; s < stall; s++) begin
        chk(dram_cmd_valid == 1'b1, "R10", 64'(dram_cmd_valid), 64'h1);
        chk(dram_cmd_addr == exp_base(a, b), "R10", 64'(dram_cmd_addr), 64'(exp_base(a, b)));
        @(negedge clk);
      end
      dram_done = 1'b1;
      @(negedge clk);
      dram_done = 1'b0;
    end
    req_valid = 1'b0;
    chk(!dram_cmd_valid && req_ready, "R9", {dram_cmd_valid, req_ready}, 2'b01);
    chk(wr_dm == 2'b00 && wr_dq == 16'h0, "R8", {wr_dm, wr_dq}, 64'h0);
  endtask

  task automatic do_read(input logic [23:0] a, input bit pair, input int seed);
    logic [15:0] bt [4];
    logic [31:0] expw;
    for (int k = 0; k < 4; k++) bt[k] = 16'(seed * 37 + k * 4099 + int'(a[15:0]));
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_pair = pair; req_addr = a; req_wdata = '1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(dram_cmd_valid && !dram_cmd_write, "R7", {dram_cmd_valid, dram_cmd_write}, 2'b10);
    chk(dram_cmd_addr == exp_base(a, 0), "R2", 64'(dram_cmd_addr), 64'(exp_base(a, 0)));
    for (int k = 0; k < 4; k++) begin
      chk(wr_dm == 2'b00 && wr_dq == 16'h0, "R8", {wr_dm, wr_dq}, 64'h0);
      rd_dq = bt[k];
      dram_beat = 1'b1;
      @(negedge clk);
      dram_beat = 1'b0;
    end
    dram_done = 1'b1;
    @(negedge clk);
    dram_done = 1'b0;
    expw = a[0] ? {bt[3], bt[2]} : {bt[1], bt[0]};
    chk(rsp_valid == 1'b1, "R7", 64'(rsp_valid), 64'h1);
    chk(rsp_rdata == expw, "R7", 64'(rsp_rdata), 64'(expw));
    chk(!dram_cmd_valid && req_ready, "R7", {dram_cmd_valid, req_ready}, 2'b01);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R7", 64'(rsp_valid), 64'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [23:0] addrs [8];
    logic [63:0] wd;
    addrs[0] = 24'h200000; addrs[1] = 24'h200001; addrs[2] = 24'h000000;
    addrs[3] = 24'h000001; addrs[4] = 24'hFFFFFF; addrs[5] = 24'hFFFFFE;
    addrs[6] = 24'h123457; addrs[7] = 24'h0ABCDE;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(req_ready == 1'b1, "R1", 64'(req_ready), 64'h1);
    chk(!dram_cmd_valid && !rsp_valid, "R1", {dram_cmd_valid, rsp_valid}, 64'h0);
    chk(wr_dm == 2'b00 && wr_dq == 16'h0, "R1", {wr_dm, wr_dq}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    // R2: the logical-to-physical example address
    req_addr = 24'h200000;
    for (int i = 0; i < 8; i++) begin
      wd = 64'h1111_2222_3333_4444 ^ (64'(i) * 64'h0101_0303_0505_0707);
      do_write(addrs[i], 1'b0, wd, 0, 1'b0);   // R4
      do_write(addrs[i], 1'b1, wd, 0, 1'b0);   // R5 / R6
      do_read(addrs[i], 1'b0, i);              // R7
      do_read(addrs[i], 1'b1, i + 20);         // R7: pair flag has no effect
    end
    // R9: competing request held through a burst
    do_write(24'h200001, 1'b1, 64'hDEAD_BEEF_CAFE_F00D, 0, 1'b1);
    do_write(24'h000010, 1'b0, 64'h0000_0000_A5A5_5A5A, 0, 1'b1);
    // R10: sequencer idles after the fourth beat
    do_write(24'h000003, 1'b1, 64'h0123_4567_89AB_CDEF, 3, 1'b0);
    do_write(24'h000004, 1'b0, 64'h0000_0000_7777_8888, 5, 1'b0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule